// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which low-power state a processor core drops into when it issues a wait request, and when it comes back out. One wait request can lead to three depths. Two configuration bits choose between them. A light sleep gates only the processor clock. A stop state gates every core-domain clock and shuts the oscillators. A standby state removes core power altogether. The wait request comes in two kinds: wait-for-interrupt and wait-for-event. The kind is remembered on entry and fixes which sources may end the light and stop states.

Standby is left only through a reset. A wake-pin rising edge, an alarm rising edge or a watchdog request starts a core-domain reset pulse. The block then returns to Run with every core-domain control bit cleared. Only the wake-pin enable is kept, because it lives in the backup domain. Leaving the stop state always forces the system clock selection back to the internal RC oscillator. If the low-power regulator was chosen, Run comes back only after a programmable settling delay. A one-bit event latch records events that arrive while running. A later wait-for-event request consumes the latch and returns at once instead of sleeping.

Top module: `lpm_sequencer`

## Requirements
- R1: With the deep bit clear, a wait request from Run enters light sleep: `state_o` = 1, `cpu_clk_en` = 0, and `periph_clk_en` and `osc_en` stay 1.
- R2: With the deep bit set and the power-down bit clear, a wait request enters stop: `state_o` = 2, and `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R3: With both the deep and power-down bits set, a wait request enters standby: `state_o` = 3, `core_pwr_off` = 1 and every clock enable is 0.
- R4: `reg_lowpower` is 1 only while in stop with the low-power-regulator bit set. It is 0 in stop with the main regulator and in every other state.
- R5: A wait-for-interrupt sleep ends only when some bit of `irq_pend & irq_en` is 1. Event lines do not end it.
- R6: A wait-for-event sleep ends when any `evt_in` bit is 1. A 0-to-1 change of an `irq_pend` bit ends it only when the pend-event bit is set.
- R7: After leaving stop, `clk_sel_rc` is 1 even if the configuration had selected the external clock (`cfg_clk_ext` = 1).
- R8: On leaving stop with the low-power regulator and a non-zero `wake_dly` = D, `state_o` stays 2 with `osc_en` = 1 for exactly D cycles after the wake edge, then shows Run. With the main regulator or D = 0, Run follows in the next cycle.
- R9: In Run, `evt_in`, `sev`, or a rising pend with the pend-event bit set, arms the event latch. A wait-for-interrupt sleep also arms it on such events. A wait-for-event request with the latch armed, or with an event in the same cycle, stays in Run and disarms the latch. So a send-event followed by two wait-for-event requests sleeps on the second.
- R10: A wait-for-interrupt request while some enabled interrupt is already pending stays in Run.
- R11: With the sleep-on-exit bit set, an `irq_exit_last` pulse in Run enters light sleep with wait-for-interrupt wake rules.
- R12: Standby ends only on a rising `wake_pin` while the backup wake-pin enable is 1, a rising `rtc_alarm`, a `wdg_rst` request, or `rst_n`. A level that was already high on entry does not end it.
- R13: Leaving standby drives `core_rst` = 1 with `state_o` = 3 and `core_pwr_off` = 0 for RST_CYC cycles, then Run. All configuration bits are cleared afterwards, and only the wake-pin enable keeps its value.
- R14: `wdg_rst` in Run or in any low-power state starts the same core reset sequence as R13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | External reset, active low, asynchronous; clears all state including backup bits |
| cfg_we | input | 1 | Loads the six core-domain configuration bits; accepted in Run only |
| cfg_deep | input | 1 | Deep select: 0 light sleep, 1 stop or standby |
| cfg_pdown | input | 1 | Power-down select under deep: 0 stop, 1 standby |
| cfg_lpreg | input | 1 | Regulator in stop: 0 main, 1 low-power |
| cfg_soe | input | 1 | Sleep-on-exit enable |
| cfg_sevpend | input | 1 | A newly pending interrupt counts as an event |
| cfg_clk_ext | input | 1 | Requests the external system clock (clears `clk_sel_rc`) |
| bkp_we | input | 1 | Loads the backup-domain wake-pin enable; accepted in Run only |
| bkp_wkpin_en | input | 1 | Wake-pin enable value |
| wake_dly | input | DLY_W | Regulator settling delay in cycles after a low-power stop |
| wait_req | input | 1 | One-cycle wait request from the core |
| wait_is_wfe | input | 1 | Wait kind: 0 wait-for-interrupt, 1 wait-for-event |
| sev | input | 1 | Send-event pulse from the core |
| irq_exit_last | input | 1 | Return from the last active interrupt handler |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Interrupt enable mask |
| evt_in | input | N_EVT | Event lines |
| wake_pin | input | 1 | External wake pin |
| rtc_alarm | input | 1 | Alarm line |
| wdg_rst | input | 1 | Watchdog reset request |
| state_o | output | 2 | 0 Run, 1 light sleep, 2 stop, 3 standby |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator and PLL enable |
| reg_lowpower | output | 1 | Regulator in low-power mode |
| core_pwr_off | output | 1 | Core domain power removed |
| core_rst | output | 1 | Core-domain reset |
| clk_sel_rc | output | 1 | System clock taken from the internal RC oscillator |

## Verification
Two functions can fall in the same clock edge: arming the event latch and consuming it with a wait-for-event request. The bench drives an event line, or a rising pend with the pend-event bit set, in the very cycle of the request. It expects the block to stay in Run and to sleep on the next wait-for-event request. Randomised rounds also let wake sources land in the cycle right after entry. The expected state comes from bench functions that combine the wait kind, the enable mask, the event lines and a bench-side copy of the latch.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    // externally visible state codes
    localparam logic [1:0] ST_RUN   = 2'd0;
    localparam logic [1:0] ST_SLEEP = 2'd1;
    localparam logic [1:0] ST_STOP  = 2'd2;
    localparam logic [1:0] ST_STBY  = 2'd3;

    typedef enum logic [2:0] {
        FS_RUN,
        FS_SLEEP,
        FS_STOP,
        FS_WKDLY,
        FS_STBY,
        FS_CRST
    } lpm_fsm_e;

    // core-domain configuration, cleared by a core reset
    typedef struct packed {
        logic deep;
        logic pdown;
        logic lpreg;
        logic soe;
        logic sevpend;
        logic clk_ext;
    } lpm_ctl_t;

    typedef struct packed {
        lpm_fsm_e fsm;
        lpm_ctl_t ctl;
        logic     wkpin_en;  // backup domain, survives core reset
        logic     evt_latch;
        logic     wait_wfe;
    } lpm_seq_t;

    localparam lpm_seq_t SEQ_RST = '{
        fsm: FS_RUN, ctl: '0, wkpin_en: 1'b0, evt_latch: 1'b0, wait_wfe: 1'b0
    };
endpackage

// File: rtl/lpm_rise_det.sv
module lpm_rise_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= prev_d[i];
        end
        assign rise_o[i] = sig_i[i] & ~prev_q[i];
    end
endmodule

// File: rtl/lpm_countdown.sv
module lpm_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         last_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = val_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == W'(1));

    AST_CNT_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int N_IRQ   = 8,
    parameter int N_EVT   = 4,
    parameter int DLY_W   = 8,
    parameter int RST_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_deep,
    input  logic             cfg_pdown,
    input  logic             cfg_lpreg,
    input  logic             cfg_soe,
    input  logic             cfg_sevpend,
    input  logic             cfg_clk_ext,
    input  logic             bkp_we,
    input  logic             bkp_wkpin_en,
    input  logic [DLY_W-1:0] wake_dly,
    input  logic             wait_req,
    input  logic             wait_is_wfe,
    input  logic             sev,
    input  logic             irq_exit_last,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_EVT-1:0] evt_in,
    input  logic             wake_pin,
    input  logic             rtc_alarm,
    input  logic             wdg_rst,
    output logic [1:0]       state_o,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             osc_en,
    output logic             reg_lowpower,
    output logic             core_pwr_off,
    output logic             core_rst,
    output logic             clk_sel_rc
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int RST_W = $clog2(RST_CYC + 1);

    lpm_seq_t seq_d, seq_q;

    logic [N_IRQ-1:0] pend_rise;
    logic [1:0]       stby_rise;
    logic             irq_any;
    logic             evt_any;
    logic             pend_evt;
    logic             run_evt;
    logic             sleep_evt;
    logic             wake_ok;
    logic             stby_wake;
    logic             dly_load, dly_last;
    logic             rst_load, rst_last;

    // edge detectors for newly pending interrupts and standby wake lines
    lpm_rise_det #(.W(N_IRQ)) u_pend_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (irq_pend),
        .rise_o (pend_rise)
    );

    lpm_rise_det #(.W(2)) u_stby_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({wake_pin, rtc_alarm}),
        .rise_o (stby_rise)
    );

    // regulator settling and core reset timers
    lpm_countdown #(.W(DLY_W)) u_dly_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (dly_load),
        .val_i  (wake_dly),
        .last_o (dly_last)
    );

    lpm_countdown #(.W(RST_W)) u_rst_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rst_load),
        .val_i  (RST_W'(RST_CYC)),
        .last_o (rst_last)
    );

    always_comb begin
        irq_any   = |(irq_pend & irq_en);
        evt_any   = |evt_in;
        pend_evt  = seq_q.ctl.sevpend & (|pend_rise);
        sleep_evt = evt_any | pend_evt;
        run_evt   = sleep_evt | sev;
        wake_ok   = seq_q.wait_wfe ? sleep_evt : irq_any;
        stby_wake = (seq_q.wkpin_en & stby_rise[1]) | stby_rise[0];
    end

    always_comb begin
        seq_d    = seq_q;
        dly_load = 1'b0;
        rst_load = 1'b0;

        unique case (seq_q.fsm)
            FS_RUN: begin
                if (cfg_we) begin
                    seq_d.ctl = '{deep: cfg_deep, pdown: cfg_pdown, lpreg: cfg_lpreg,
                                  soe: cfg_soe, sevpend: cfg_sevpend, clk_ext: cfg_clk_ext};
                end
                if (bkp_we) seq_d.wkpin_en = bkp_wkpin_en;
                if (run_evt) seq_d.evt_latch = 1'b1;

                if (wait_req) begin
                    if (wait_is_wfe && (seq_q.evt_latch || run_evt)) begin
                        // pending event consumed, no sleep
                        seq_d.evt_latch = 1'b0;
                    end else if (!wait_is_wfe && irq_any) begin
                        seq_d.fsm = FS_RUN;
                    end else begin
                        seq_d.wait_wfe = wait_is_wfe;
                        if (!seq_q.ctl.deep)      seq_d.fsm = FS_SLEEP;
                        else if (seq_q.ctl.pdown) seq_d.fsm = FS_STBY;
                        else                      seq_d.fsm = FS_STOP;
                    end
                end else if (irq_exit_last && seq_q.ctl.soe) begin
                    seq_d.fsm      = FS_SLEEP;
                    seq_d.wait_wfe = 1'b0;
                end
            end
            FS_SLEEP: begin
                if (!seq_q.wait_wfe && sleep_evt) seq_d.evt_latch = 1'b1;
                if (wake_ok) seq_d.fsm = FS_RUN;
            end
            FS_STOP: begin
                if (!seq_q.wait_wfe && sleep_evt) seq_d.evt_latch = 1'b1;
                if (wake_ok) begin
                    seq_d.ctl.clk_ext = 1'b0;
                    if (seq_q.ctl.lpreg && wake_dly != '0) begin
                        seq_d.fsm = FS_WKDLY;
                        dly_load  = 1'b1;
                    end else begin
                        seq_d.fsm = FS_RUN;
                    end
                end
            end
            FS_WKDLY: begin
                if (dly_last) seq_d.fsm = FS_RUN;
            end
            FS_STBY: begin
                if (stby_wake) begin
                    seq_d.fsm       = FS_CRST;
                    seq_d.ctl       = '0;
                    seq_d.evt_latch = 1'b0;
                    seq_d.wait_wfe  = 1'b0;
                    rst_load        = 1'b1;
                end
            end
            FS_CRST: begin
                if (rst_last) seq_d.fsm = FS_RUN;
            end
            default: seq_d = SEQ_RST;
        endcase

        // watchdog overrides everything except an ongoing core reset
        if (wdg_rst && seq_q.fsm != FS_CRST) begin
            seq_d.fsm       = FS_CRST;
            seq_d.ctl       = '0;
            seq_d.evt_latch = 1'b0;
            seq_d.wait_wfe  = 1'b0;
            rst_load        = 1'b1;
            dly_load        = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    always_comb begin
        unique case (seq_q.fsm)
            FS_RUN:             state_o = ST_RUN;
            FS_SLEEP:           state_o = ST_SLEEP;
            FS_STOP, FS_WKDLY:  state_o = ST_STOP;
            FS_STBY, FS_CRST:   state_o = ST_STBY;
            default:            state_o = ST_RUN;
        endcase
        cpu_clk_en    = (seq_q.fsm == FS_RUN);
        periph_clk_en = (seq_q.fsm == FS_RUN) || (seq_q.fsm == FS_SLEEP);
        osc_en        = (seq_q.fsm == FS_RUN) || (seq_q.fsm == FS_SLEEP) ||
                        (seq_q.fsm == FS_WKDLY) || (seq_q.fsm == FS_CRST);
        reg_lowpower  = (seq_q.fsm == FS_STOP) && seq_q.ctl.lpreg;
        core_pwr_off  = (seq_q.fsm == FS_STBY);
        core_rst      = (seq_q.fsm == FS_CRST);
        clk_sel_rc    = !seq_q.ctl.clk_ext;
    end

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.fsm == FS_RUN && wait_req && !wait_is_wfe && !irq_any && !wdg_rst && !seq_q.ctl.deep)
        |=> (state_o == ST_SLEEP && periph_clk_en && !cpu_clk_en)); // R1

    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.fsm == FS_RUN && wait_req && !wait_is_wfe && !irq_any && !wdg_rst &&
         seq_q.ctl.deep && !seq_q.ctl.pdown)
        |=> (state_o == ST_STOP && !periph_clk_en && !osc_en)); // R2

    AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.fsm == FS_STBY && !stby_wake && !wdg_rst) |=> core_pwr_off); // R12

    AST_WFE_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.fsm == FS_RUN && wait_req && wait_is_wfe && seq_q.evt_latch && !wdg_rst)
        |=> (cpu_clk_en && !seq_q.evt_latch)); // R9

    AST_RC_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_clk_en) && $past(state_o) == ST_STOP) |-> clk_sel_rc); // R7

    AST_CRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> (cpu_clk_en && !seq_q.ctl.deep && !seq_q.ctl.soe)); // R13
endmodule

// File: tb/lpm_sequencer_bench.sv
module lpm_sequencer_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int N_IRQ = 8;
    localparam int N_EVT = 4;
    localparam int DLY_W = 8;
    localparam int RST_CYC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_deep = 0, cfg_pdown = 0, cfg_lpreg = 0, cfg_soe = 0;
    logic cfg_sevpend = 0, cfg_clk_ext = 0, bkp_we = 0, bkp_wkpin_en = 0;
    logic [DLY_W-1:0] wake_dly = '0;
    logic wait_req = 0, wait_is_wfe = 0, sev = 0, irq_exit_last = 0;
    logic [N_IRQ-1:0] irq_pend = '0, irq_en = '0;
    logic [N_EVT-1:0] evt_in = '0;
    logic wake_pin = 0, rtc_alarm = 0, wdg_rst = 0;
    logic [1:0] state_o;
    logic cpu_clk_en, periph_clk_en, osc_en, reg_lowpower, core_pwr_off, core_rst, clk_sel_rc;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit lat = 0;

    lpm_sequencer #(.N_IRQ(N_IRQ), .N_EVT(N_EVT), .DLY_W(DLY_W), .RST_CYC(RST_CYC)) u_lpm_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_deep(cfg_deep), .cfg_pdown(cfg_pdown),
        .cfg_lpreg(cfg_lpreg), .cfg_soe(cfg_soe), .cfg_sevpend(cfg_sevpend), .cfg_clk_ext(cfg_clk_ext),
        .bkp_we(bkp_we), .bkp_wkpin_en(bkp_wkpin_en), .wake_dly(wake_dly), .wait_req(wait_req),
        .wait_is_wfe(wait_is_wfe), .sev(sev), .irq_exit_last(irq_exit_last), .irq_pend(irq_pend),
        .irq_en(irq_en), .evt_in(evt_in), .wake_pin(wake_pin), .rtc_alarm(rtc_alarm), .wdg_rst(wdg_rst),
        .state_o(state_o), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
        .reg_lowpower(reg_lowpower), .core_pwr_off(core_pwr_off), .core_rst(core_rst),
        .clk_sel_rc(clk_sel_rc)
    );

    always #2.5 clk = ~clk;

    function automatic logic [1:0] exp_entry(input logic deep, input logic pdown);
        if (!deep) return 2'd1;
        return pdown ? 2'd3 : 2'd2;
    endfunction

    function automatic logic exp_wake(input logic wfe, input logic sevp, input logic [N_IRQ-1:0] lvl,
                                      input logic [N_IRQ-1:0] en, input logic [N_IRQ-1:0] rise,
                                      input logic [N_EVT-1:0] ev);
        if (wfe) return (|ev) || (sevp && (|rise));
        return |(lvl & en);
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input logic d, input logic p, input logic l, input logic s,
                             input logic sp, input logic ce);
        cfg_deep = d; cfg_pdown = p; cfg_lpreg = l; cfg_soe = s; cfg_sevpend = sp; cfg_clk_ext = ce;
        cfg_we = 1; step(); cfg_we = 0;
    endtask

    task automatic write_bkp(input logic w);
        bkp_wkpin_en = w; bkp_we = 1; step(); bkp_we = 0;
    endtask

    task automatic do_wait(input logic wfe);
        wait_req = 1; wait_is_wfe = wfe; step(); wait_req = 0;
    endtask

    task automatic irq_wake();
        irq_en[0] = 1; irq_pend[0] = 1; step(); irq_pend[0] = 0;
    endtask

    task automatic ride_reset(input string req);
        for (int k = 1; k < RST_CYC; k++) begin
            step(); check(req, core_rst, 1);
        end
        step(); check(req, core_rst, 0); check(req, state_o, 0);
    endtask

    task automatic expect_wake(input logic deep, input logic lp, input int dly, input string tag);
        if (deep && lp && dly != 0) begin
            for (int k = 0; k < dly; k++) begin
                check("R8", state_o, 2); check("R8", osc_en, 1);
                evt_in = '0; irq_pend = '0; step();
            end
        end
        check(tag, state_o, 0);
        if (deep) check("R7", clk_sel_rc, 1);
        evt_in = '0; irq_pend = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic r_deep, r_lp, r_sev, r_wfe, w;
        logic [N_IRQ-1:0] r_en, r_pend;
        logic [N_EVT-1:0] r_evt;
        logic [1:0] ecode;
        int r_dly;
        int unused_seed;
        unused_seed = $urandom(32'd7321);

        step(); step(); rst_n = 1; step();
        check("R1 reset", state_o, 0); check("R1 reset", cpu_clk_en, 1);
        check("R7 reset", clk_sel_rc, 1); check("R13 reset", core_rst, 0);
        check("R3 reset", core_pwr_off, 0);

        // light sleep, wait-for-interrupt
        write_cfg(0, 0, 0, 0, 0, 0);
        do_wait(0);
        check("R1", state_o, 1); check("R1", cpu_clk_en, 0);
        check("R1", periph_clk_en, 1); check("R1", osc_en, 1); check("R4", reg_lowpower, 0);
        evt_in = 4'b0001; step(); evt_in = '0;
        check("R5 event ignored", state_o, 1);
        irq_wake();
        check("R5", state_o, 0);
        irq_en = '0; step();
        // latch armed by event during WFI sleep
        do_wait(1); check("R9 latched", state_o, 0);
        sev = 1; step(); sev = 0;
        do_wait(1); check("R9 sev first wait", state_o, 0);
        do_wait(1); check("R9 sev second wait", state_o, 1);
        irq_pend[1] = 1; step();
        check("R6 pend without sevpend", state_o, 1);
        irq_pend[1] = 0; step();
        evt_in[2] = 1; step(); evt_in = '0;
        check("R6 event wake", state_o, 0);
        // pend rise as event
        write_cfg(0, 0, 0, 0, 1, 0);
        do_wait(1); check("R6", state_o, 1);
        irq_pend[3] = 1; step(); irq_pend = '0;
        check("R6 pend with sevpend", state_o, 0);
        step();
        // event in the same cycle as the WFE request
        evt_in[1] = 1; do_wait(1); evt_in = '0;
        check("R9 same cycle", state_o, 0);
        do_wait(1); check("R9 after same cycle", state_o, 1);
        evt_in[0] = 1; step(); evt_in = '0; check("R6", state_o, 0);
        // WFI with enabled interrupt already pending
        irq_en[0] = 1; irq_pend[0] = 1; step();
        do_wait(0); check("R10", state_o, 0);
        irq_pend = '0; irq_en = '0; step();

        // low-power stop with settling delay
        wake_dly = 8'd5;
        write_cfg(1, 0, 1, 0, 0, 1);
        check("R7 ext selected", clk_sel_rc, 0);
        do_wait(0);
        check("R2", state_o, 2); check("R2", periph_clk_en, 0); check("R2", osc_en, 0);
        check("R4 lp", reg_lowpower, 1);
        evt_in = 4'b1000; step(); evt_in = '0;
        check("R5 stop event ignored", state_o, 2);
        irq_en[0] = 1; irq_pend[0] = 1; step();
        check("R4 left stop", reg_lowpower, 0);
        expect_wake(1, 1, 5, "R8");
        irq_en = '0; step();
        // main regulator stop
        write_cfg(1, 0, 0, 0, 0, 1);
        do_wait(0); check("R4 main", reg_lowpower, 0); check("R2", state_o, 2);
        irq_en[0] = 1; irq_pend[0] = 1; step();
        check("R8 main", state_o, 0); check("R7", clk_sel_rc, 1);
        irq_pend = '0; irq_en = '0; step();

        // sleep on exit
        write_cfg(0, 0, 0, 1, 0, 0);
        irq_exit_last = 1; step(); irq_exit_last = 0;
        check("R11", state_o, 1);
        evt_in = 4'b0100; step(); evt_in = '0; check("R11 wfi rules", state_o, 1);
        irq_wake(); check("R11 wake", state_o, 0);
        irq_en = '0; step();

        // standby, wake pin disabled, alarm exit
        write_cfg(1, 1, 0, 1, 1, 0);
        do_wait(0);
        check("R3", state_o, 3); check("R3", core_pwr_off, 1);
        check("R3", cpu_clk_en, 0); check("R3", osc_en, 0);
        wake_pin = 1; step(); check("R12 pin disabled", core_pwr_off, 1);
        wake_pin = 0; step();
        irq_en[0] = 1; irq_pend[0] = 1; evt_in = 4'b1111; step();
        check("R12 irq ignored", core_pwr_off, 1);
        irq_pend = '0; irq_en = '0; evt_in = '0; step();
        rtc_alarm = 1; step(); rtc_alarm = 0;
        check("R13", core_rst, 1); check("R13", core_pwr_off, 0); check("R13", state_o, 3);
        ride_reset("R13");
        do_wait(0); check("R13 deep cleared", state_o, 1);
        irq_wake(); irq_en = '0; step();
        irq_exit_last = 1; step(); irq_exit_last = 0;
        check("R13 soe cleared", state_o, 0);

        // wake pin enabled, level high at entry
        write_bkp(1);
        write_cfg(1, 1, 0, 0, 0, 0);
        wake_pin = 1; step();
        do_wait(0); check("R3", state_o, 3);
        step(); check("R12 level high", core_pwr_off, 1);
        wake_pin = 0; step();
        wake_pin = 1; step(); check("R12 pin edge", core_rst, 1);
        wake_pin = 0;
        ride_reset("R13");
        write_cfg(1, 1, 0, 0, 0, 0);
        do_wait(0); check("R3", core_pwr_off, 1);
        wake_pin = 1; step(); wake_pin = 0;
        check("R13 wake enable kept", core_rst, 1);
        ride_reset("R13");

        // watchdog from light sleep
        do_wait(0); check("R14 pre", state_o, 1);
        wdg_rst = 1; step(); wdg_rst = 0;
        check("R14", core_rst, 1); check("R14", state_o, 3);
        ride_reset("R14");
        lat = 0;

        // randomised rounds
        for (int it = 0; it < 60; it++) begin
            r_deep = 1'($urandom % 2); r_lp = 1'($urandom % 2); r_sev = 1'($urandom % 2);
            r_wfe = 1'($urandom % 2); r_dly = int'($urandom % 4); r_en = N_IRQ'($urandom);
            wake_dly = DLY_W'(r_dly); irq_en = r_en;
            write_cfg(r_deep, 0, r_lp, 0, r_sev, 1);
            do_wait(r_wfe);
            if (r_wfe && lat) begin
                check("R9 random consume", state_o, 0);
                lat = 0;
                continue;
            end
            ecode = exp_entry(r_deep, 1'b0);
            check(r_deep ? "R2 random" : "R1 random", state_o, ecode);
            r_evt = ($urandom % 3 == 0) ? N_EVT'($urandom) : '0;
            r_pend = ($urandom % 2 == 0) ? N_IRQ'($urandom) : '0;
            evt_in = r_evt; irq_pend = r_pend; step();
            w = exp_wake(r_wfe, r_sev, r_pend, r_en, r_pend, r_evt);
            if (!r_wfe && ((|r_evt) || (r_sev && (|r_pend)))) lat = 1;
            if (w) begin
                expect_wake(r_deep, r_lp, r_dly, r_wfe ? "R6 random" : "R5 random");
            end else begin
                check(r_wfe ? "R6 random hold" : "R5 random hold", state_o, ecode);
                evt_in = '0; irq_pend = '0; step();
                if (r_wfe) begin
                    evt_in[0] = 1;
                end else begin
                    irq_en[0] = 1; irq_pend[0] = 1;
                    if (r_sev) lat = 1;
                end
                step();
                expect_wake(r_deep, r_lp, r_dly, r_wfe ? "R6 random" : "R5 random");
            end
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule